// File: doc/BRIEF.md
# Dual-Port Status Lamp Controller

This block drives two bicolour (red and green) status lamps on a programming pod that has a serial/JTAG/SPI target port, a byte-wide parallel target port and a socketed adapter port. Lamp 0 belongs to the serial/JTAG/SPI port and lamp 1 to the byte-wide port. From the pod power state, the host link state, the active-port selection, the two target reference-good flags and an over-current fault flag, it works out which colour each lamp shows. Amber is produced by lighting the red and green elements at the same time.

The active-port selection is held in a register. Reset loads a parameterised default into it. After that it changes only on a write strobe from the host. An over-current event is latched. While it is latched, both lamps blink red from a parameterised prescaler until the host clears it. The reference-good flags come from voltage comparators in another clock domain, so they pass through a synchroniser before the lamp logic uses them. Voltage measurement and current sensing are done outside this block.

Top module: `ledstat_ctrl`

## Requirements
- R1: While reset is asserted or pod_pwr is low, all four lamp elements are off. This holds even if an over-current fault is latched.
- R2: After reset the selection is the serial/JTAG/SPI port, code 0. With the host link present, no fault and ref_ok[0] high, lamp 0 is green and lamp 1 is red.
- R3: With code 0 selected, lamp 0 is amber (red and green both lit) when ref_ok[0] is low and green when it is high. Lamp 1 is red.
- R4: With the byte-wide port selected (code 1), lamp 1 is amber when ref_ok[1] is low and green when it is high. Lamp 0 is red.
- R5: With the adapter port (code 2) or no port (code 3) selected, both lamps are steady red and neither green element is lit.
- R6: When the pod is powered, no fault is latched and host_link is low, both lamps are amber whatever the selection.
- R7: A high oc_fault latches a fault. While the fault is latched and the pod is powered, both lamps show red together and blink with a 50% duty cycle over a period of 2*BLINK_DIV clocks. No green is lit. This overrides the host link and selection indications.
- R8: The latched fault is removed only by oc_clear with oc_fault low. If both are high in the same cycle, the fault stays latched.
- R9: The selection register loads sel_code only in a cycle with sel_wr high. At any other time sel_code has no effect.
- R10: Each ref_ok bit passes through SYNC_STAGES flip-flops. A change does not reach the lamps within the first two clocks, and does reach them within SYNC_STAGES+OUT_REG+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pod_pwr | input | 1 | Pod supply present |
| host_link | input | 1 | Host parallel link connected |
| sel_wr | input | 1 | Host strobe that loads sel_code |
| sel_code | input | 2 | Port code: 0 serial/JTAG/SPI, 1 byte-wide, 2 adapter, 3 none |
| ref_ok | input | 2 | Asynchronous reference-good flags: bit 0 serial port, bit 1 byte-wide port |
| oc_fault | input | 1 | Over-current event on the adapter port |
| oc_clear | input | 1 | Host command that clears the latched fault |
| lamp0_red | output | 1 | Serial/JTAG/SPI lamp, red element |
| lamp0_grn | output | 1 | Serial/JTAG/SPI lamp, green element |
| lamp1_red | output | 1 | Byte-wide lamp, red element |
| lamp1_grn | output | 1 | Byte-wide lamp, green element |

## Verification
The bench builds the block with BLINK_DIV=4, so one blink period is eight clocks and two full periods fit in a short sampling window. That makes the 50% duty cycle and the override by a fault checkable by counting lit samples. SYNC_STAGES=2 and OUT_REG=1 fix the reference-flag latency at three clocks, so the "not yet visible" and "now visible" sides of R10 can each be sampled on a known cycle. DEFAULT_SEL=0 makes the serial port the reset-time selection.

// File: rtl/ledstat_pkg.sv
package ledstat_pkg;

   typedef enum logic [1:0] {
      PSEL_SJS   = 2'd0,
      PSEL_BYTE  = 2'd1,
      PSEL_ADAPT = 2'd2,
      PSEL_NONE  = 2'd3
   } psel_e;

   typedef struct packed {
      logic red;
      logic grn;
   } lamp_t;

   localparam lamp_t LAMP_OFF   = '{red: 1'b0, grn: 1'b0};
   localparam lamp_t LAMP_RED   = '{red: 1'b1, grn: 1'b0};
   localparam lamp_t LAMP_GREEN = '{red: 1'b0, grn: 1'b1};
   localparam lamp_t LAMP_AMBER = '{red: 1'b1, grn: 1'b1};

   // colour of a port lamp from its selection and reference state
   function automatic lamp_t port_lamp(input logic selected, input logic ref_good);
      if (!selected)     return LAMP_RED;
      else if (ref_good) return LAMP_GREEN;
      else               return LAMP_AMBER;
   endfunction

endpackage

// File: rtl/ledstat_sync.sv
module ledstat_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ledstat_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ledstat_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ledstat_blink.sv
module ledstat_blink #(
   parameter int BLINK_DIV = 12_500_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);

   if (BLINK_DIV < 1) begin : g_bad_div
      $error("ledstat_blink: BLINK_DIV must be at least 1");
   end

   logic phase_q;

   if (BLINK_DIV == 1) begin : g_every_clk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase_q <= 1'b0;
         else        phase_q <= ~phase_q;
      end
   end else begin : g_prescaled
      localparam int CW = $clog2(BLINK_DIV);
      localparam logic [CW-1:0] LAST = CW'(BLINK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
         end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/ledstat_selreg.sv
module ledstat_selreg
   import ledstat_pkg::*;
#(
   parameter int DEFAULT_SEL = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] code,
   output psel_e      sel
);

   if (DEFAULT_SEL < 0 || DEFAULT_SEL > 3) begin : g_bad_default
      $error("ledstat_selreg: DEFAULT_SEL must be 0..3");
   end

   localparam logic [1:0] DEF_CODE = 2'(DEFAULT_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sel <= psel_e'(DEF_CODE);
      else if (wr) sel <= psel_e'(code);
   end

endmodule

// File: rtl/ledstat_ctrl.sv
module ledstat_ctrl
   import ledstat_pkg::*;
#(
   parameter int BLINK_DIV   = 12_500_000,
   parameter int SYNC_STAGES = 2,
   parameter int DEFAULT_SEL = 0,
   parameter int OUT_REG     = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pod_pwr,
   input  logic       host_link,
   input  logic       sel_wr,
   input  logic [1:0] sel_code,
   input  logic [1:0] ref_ok,
   input  logic       oc_fault,
   input  logic       oc_clear,
   output logic       lamp0_red,
   output logic       lamp0_grn,
   output logic       lamp1_red,
   output logic       lamp1_grn
);

   localparam int NPORT = 2;

   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("ledstat_ctrl: OUT_REG must be 0 or 1");
   end

   logic [NPORT-1:0] ref_s;
   logic             blink_on;
   psel_e            sel_q;
   logic             fault_q;
   lamp_t            nxt [NPORT];
   lamp_t            cur [NPORT];

   ledstat_sync #(.WIDTH(NPORT), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ref_ok),
      .dout (ref_s)
   );

   ledstat_blink #(.BLINK_DIV(BLINK_DIV)) u_blink (
      .clk  (clk),
      .rst_n(rst_n),
      .phase(blink_on)
   );

   ledstat_selreg #(.DEFAULT_SEL(DEFAULT_SEL)) u_sel (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (sel_wr),
      .code (sel_code),
      .sel  (sel_q)
   );

   // sticky over-current: a new event beats a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fault_q <= 1'b0;
      else if (oc_fault) fault_q <= 1'b1;
      else if (oc_clear) fault_q <= 1'b0;
   end

   // priority: power, fault, host link, port selection
   always_comb begin
      for (int p = 0; p < NPORT; p++) begin
         if (!pod_pwr)
            nxt[p] = LAMP_OFF;
         else if (fault_q)
            nxt[p] = blink_on ? LAMP_RED : LAMP_OFF;
         else if (!host_link)
            nxt[p] = LAMP_AMBER;
         else
            nxt[p] = port_lamp(sel_q == psel_e'(2'(p)), ref_s[p]);
      end
   end

   if (OUT_REG == 1) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cur[0] <= LAMP_OFF;
            cur[1] <= LAMP_OFF;
         end else begin
            cur[0] <= nxt[0];
            cur[1] <= nxt[1];
         end
      end
   end else begin : g_out_comb
      always_comb begin
         cur[0] = rst_n ? nxt[0] : LAMP_OFF;
         cur[1] = rst_n ? nxt[1] : LAMP_OFF;
      end
   end

   assign lamp0_red = cur[0].red;
   assign lamp0_grn = cur[0].grn;
   assign lamp1_red = cur[1].red;
   assign lamp1_grn = cur[1].grn;

endmodule

// File: rtl/ledstat_ctrl_chk.sv
module ledstat_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pod_pwr,
   input logic       host_link,
   input logic       sel_wr,
   input logic [1:0] sel_code,
   input logic       oc_fault,
   input logic       oc_clear,
   input logic       fault_q,
   input logic [1:0] sel_q,
   input logic       lamp0_red,
   input logic       lamp0_grn,
   input logic       lamp1_red,
   input logic       lamp1_grn
);

   logic live_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   // R1: two cycles without power leave every element dark
   a_r1_dark_unpowered: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      (!pod_pwr && !$past(pod_pwr)) |-> !(lamp0_red || lamp0_grn || lamp1_red || lamp1_grn));

   // R7: an event latches the fault
   a_r7_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
      oc_fault |=> fault_q);

   // R7: no green while a fault is latched
   a_r7_no_green: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      (fault_q && $past(fault_q)) |-> (!lamp0_grn && !lamp1_grn && lamp0_red == lamp1_red));

   // R8: only a clear removes the fault
   a_r8_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && !oc_clear) |=> fault_q);

   // R8: clear without a new event empties the latch
   a_r8_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_clear && !oc_fault) |=> !fault_q);

   // R9: selection holds without a write
   a_r9_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr |=> $stable(sel_q));

   // R9: a write loads the code
   a_r9_sel_loads: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (sel_q == $past(sel_code)));

   // R5: adapter selection with link and no fault gives steady red on both
   a_r5_adapter_red: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      (pod_pwr && $past(pod_pwr) && host_link && $past(host_link) &&
       !fault_q && !$past(fault_q) && sel_q == 2'd2 && $past(sel_q) == 2'd2)
      |-> (lamp0_red && lamp1_red && !lamp0_grn && !lamp1_grn));

endmodule

bind ledstat_ctrl ledstat_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pod_pwr  (pod_pwr),
   .host_link(host_link),
   .sel_wr   (sel_wr),
   .sel_code (sel_code),
   .oc_fault (oc_fault),
   .oc_clear (oc_clear),
   .fault_q  (fault_q),
   .sel_q    (sel_q),
   .lamp0_red(lamp0_red),
   .lamp0_grn(lamp0_grn),
   .lamp1_red(lamp1_red),
   .lamp1_grn(lamp1_grn)
);

// File: tb/ledstat_ctrl_bench.sv
module ledstat_ctrl_bench;

   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pod_pwr = 1'b1;
   logic       host_link = 1'b1;
   logic       sel_wr = 1'b0;
   logic [1:0] sel_code = 2'd0;
   logic [1:0] ref_ok = 2'b11;
   logic       oc_fault = 1'b0;
   logic       oc_clear = 1'b0;
   logic       lamp0_red, lamp0_grn, lamp1_red, lamp1_grn;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] exp;
      string      req;
   } sb_item_t;

   sb_item_t sb_q[$];

   always #10 clk = ~clk;

   ledstat_ctrl #(
      .BLINK_DIV(DIV), .SYNC_STAGES(2), .DEFAULT_SEL(0), .OUT_REG(1)
   ) u_ledstat_ctrl (
      .clk(clk), .rst_n(rst_n), .pod_pwr(pod_pwr), .host_link(host_link),
      .sel_wr(sel_wr), .sel_code(sel_code), .ref_ok(ref_ok),
      .oc_fault(oc_fault), .oc_clear(oc_clear),
      .lamp0_red(lamp0_red), .lamp0_grn(lamp0_grn),
      .lamp1_red(lamp1_red), .lamp1_grn(lamp1_grn)
   );

   function automatic logic [3:0] lamps();
      return {lamp0_red, lamp0_grn, lamp1_red, lamp1_grn};
   endfunction

   task automatic check(input bit ok, input string req, input string act, input string exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   // monitor: compares the settled outputs against queued expectations
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         check(lamps() === it.exp, it.req, $sformatf("%b", lamps()), $sformatf("%b", it.exp));
      end
   end

   // driver: let inputs settle, then queue the expected lamp state {r0,g0,r1,g1}
   task automatic expect_lamps(input logic [3:0] e, input string req);
      repeat (6) @(negedge clk);
      sb_q.push_back('{exp: e, req: req});
      wait (sb_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic write_sel(input logic [1:0] c);
      @(negedge clk);
      sel_code = c;
      sel_wr = 1'b1;
      @(negedge clk);
      sel_wr = 1'b0;
      sel_code = ~c;
   endtask

   task automatic pulse_fault(input bit with_clear);
      @(negedge clk);
      oc_fault = 1'b1;
      oc_clear = with_clear;
      @(negedge clk);
      oc_fault = 1'b0;
      oc_clear = 1'b0;
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      oc_clear = 1'b1;
      @(negedge clk);
      oc_clear = 1'b0;
   endtask

   // two full blink periods: red lit half the samples, both lamps equal, no green
   task automatic check_blink(input string req);
      int lit = 0;
      bit bad = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 4 * DIV; i++) begin
         @(negedge clk);
         if (lamp0_red) lit++;
         if (lamp0_grn || lamp1_grn || (lamp0_red != lamp1_red)) bad = 1'b1;
      end
      check(lit == 2 * DIV && !bad, req,
            $sformatf("lit=%0d mismatch=%0b", lit, bad),
            $sformatf("lit=%0d mismatch=0", 2 * DIV));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(lamps() === 4'b0000, "R1", $sformatf("%b", lamps()), "0000");
      rst_n = 1'b1;

      expect_lamps(4'b0110, "R2");                 // serial green, byte red
      ref_ok = 2'b10;
      expect_lamps(4'b1110, "R3");                 // serial amber
      ref_ok = 2'b11;
      expect_lamps(4'b0110, "R3");

      @(negedge clk); sel_code = 2'd1;             // no strobe: ignored
      expect_lamps(4'b0110, "R9");

      write_sel(2'd1);
      ref_ok = 2'b10;
      expect_lamps(4'b1001, "R4");                 // byte green
      ref_ok = 2'b00;
      expect_lamps(4'b1011, "R4");                 // byte amber

      write_sel(2'd2);
      expect_lamps(4'b1010, "R5");
      write_sel(2'd3);
      expect_lamps(4'b1010, "R5");

      host_link = 1'b0;
      expect_lamps(4'b1111, "R6");
      write_sel(2'd0);
      expect_lamps(4'b1111, "R6");
      host_link = 1'b1;
      ref_ok = 2'b11;
      expect_lamps(4'b0110, "R2");

      // R10: reference change hidden for two clocks, visible afterwards
      @(negedge clk);
      ref_ok = 2'b10;
      repeat (2) @(negedge clk);
      check(lamps() === 4'b0110, "R10", $sformatf("%b", lamps()), "0110");
      repeat (2) @(negedge clk);
      check(lamps() === 4'b1110, "R10", $sformatf("%b", lamps()), "1110");
      ref_ok = 2'b11;

      // R7: fault blinks and overrides link state
      pulse_fault(1'b0);
      check_blink("R7");
      host_link = 1'b0;
      check_blink("R7");
      host_link = 1'b1;

      // R8: clear together with new event keeps the fault
      pulse_fault(1'b1);
      check_blink("R8");
      pulse_clear();
      expect_lamps(4'b0110, "R8");

      // R1: unpowered pod dark even with a latched fault
      pod_pwr = 1'b0;
      expect_lamps(4'b0000, "R1");
      pulse_fault(1'b0);
      expect_lamps(4'b0000, "R1");
      pod_pwr = 1'b1;
      check_blink("R7");
      pulse_clear();
      expect_lamps(4'b0110, "R8");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog R1..run actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule